// File: doc/BRIEF.md
# Half-Iteration Sequencer with Early Stop

This block is the control sequencer of an iterative soft-decision decoder that works in half-iteration steps. A start pulse captures the block length, the window length, the last half-iteration index, the early-stop mode and the stop threshold. The sequencer then runs a chain of fixed-length half-iterations. It publishes the current half-iteration index, and in each half-iteration it raises a read strobe with an address for the main received symbols and a read strobe with an address for the tail symbols. The arithmetic, the memories and the interleaving are not part of this block. They appear only as the idle cycles that make up each half-iteration.

When the current half-iteration finishes, the block compares the smallest extrinsic magnitude that the datapath reports with the threshold. Whether that comparison may count depends on the parity of the index. After a qualifying comparison, the sequencer runs exactly one more half-iteration, which the datapath uses to store its output, and then raises the done flag. The pins are plain control and status pins. There is no back-pressure: the datapath must accept a read in every cycle that a strobe is high.

Top module: `hi_sequencer`

## Requirements
- R1: While reset is high at a clock edge, every register is cleared. After that edge `dec_done` is 1, `half_idx` is 0, and `main_rdy` and `tail_rdy` are 0.
- R2: A start accepted at a clock edge makes `dec_done` 0 from that edge onward. `dec_done` stays 0 for exactly H*P cycles, where P = blk_len/8 + 2*win_len + 10 and H is the number of half-iterations that run.
- R3: `half_idx` is 0 in the first half-iteration and rises by one at each half-iteration boundary. Without an early stop, the final half-iteration has index `last_idx`, so H = last_idx + 1.
- R4: In cycle c of a half-iteration (c counted from 0), `main_rdy` is 1 exactly when c < blk_len/8 + win_len. `main_addr` is c for c < blk_len/8, and c - win_len otherwise, so the last window is read a second time.
- R5: `tail_rdy` is 1 exactly in cycles 0 to 2 of each half-iteration. `tail_addr` is c when `half_idx` is even and c + 3 when it is odd.
- R6: A start in any busy cycle has no effect, with one exception: the final cycle of the final half-iteration. A start there begins a new decode at index 0, and `dec_done` does not rise in between.
- R7: `stop_mode` encoding: 0 never stops early. 1 allows a stop only when `half_idx` is even, which means an odd count of completed half-iterations. 2 allows a stop only when `half_idx` is odd. 3 allows a stop at any index.
- R8: The stop condition is `min_mag > stop_thr` (strictly greater). It is sampled only in the final cycle of each half-iteration.
- R9: Once the stop condition is met at index n < last_idx, exactly one more half-iteration (index n+1) runs, and then decoding ends. A condition met at n = last_idx adds no half-iteration.
- R10: The configuration is captured at an accepted start. Changing the configuration inputs during a decode does not change its length or its strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse |
| blk_len | input | 13 | Block length K; its upper bits give K/8 |
| win_len | input | 7 | Sliding window length L |
| last_idx | input | 6 | Index of the last half-iteration when there is no early stop |
| stop_mode | input | 2 | Early-stop mode (see R7) |
| stop_thr | input | 7 | Early-stop threshold |
| min_mag | input | 7 | Smallest extrinsic magnitude of the half-iteration now ending |
| half_idx | output | 6 | Current half-iteration index |
| dec_done | output | 1 | High when idle or finished, low while decoding |
| main_rdy | output | 1 | Read strobe for the main received data |
| main_addr | output | 10 | Read address for the main received data |
| tail_rdy | output | 1 | Read strobe for the tail data |
| tail_addr | output | 3 | Read address for the tail data |

## Verification
The assertions check on every cycle the local rules. The index holds inside a half-iteration and grows by one at each boundary. The strobes are never high outside a decode. A tail burst begins on an address that is a multiple of three. A pending stop always ends the decode, or restarts it, at the next boundary. Only the bench's scenarios show the overall results: the number of half-iterations each mode and threshold produce, the strict comparison at equality, the rule that no half-iteration is added when the stop falls on the last index, the handling of a start in the middle of a decode against a start at the handover cycle, and the full per-cycle profile of the strobes and addresses.

// File: rtl/hi_seq_pkg.sv
package hi_seq_pkg;
  typedef enum logic [1:0] {
    STOP_NEVER    = 2'd0,
    STOP_EVEN_IDX = 2'd1,
    STOP_ODD_IDX  = 2'd2,
    STOP_ANY      = 2'd3
  } stop_mode_e;

  function automatic logic parity_allows(stop_mode_e m, logic idx_odd);
    case (m)
      STOP_EVEN_IDX: return !idx_odd;
      STOP_ODD_IDX:  return idx_odd;
      STOP_ANY:      return 1'b1;
      default:       return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/hi_stop_judge.sv
module hi_stop_judge
  import hi_seq_pkg::*;
#(
  parameter int ZW = 7
) (
  input  stop_mode_e     mode,
  input  logic           idx_odd,
  input  logic [ZW-1:0]  thr,
  input  logic [ZW-1:0]  mag,
  output logic           hit
);
  always_comb hit = parity_allows(mode, idx_odd) && (mag > thr);
endmodule

// File: rtl/hi_phase_timer.sv
module hi_phase_timer #(
  parameter int AW = 10,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          clr,
  input  logic [AW-1:0] kq,
  input  logic [LW-1:0] win,
  input  logic          idx_odd,
  output logic          last,
  output logic          main_rdy,
  output logic [AW-1:0] main_addr,
  output logic          tail_rdy,
  output logic [2:0]    tail_addr
);
  localparam int CW = AW + 2;
  localparam int TAIL_LEN = 3;

  logic [CW-1:0] cnt;
  logic [CW-1:0] period;
  logic [CW-1:0] read_len;

  always_comb begin
    period   = CW'(kq) + CW'({win, 1'b0}) + CW'(10);
    read_len = CW'(kq) + CW'(win);
    last     = run && (cnt == period - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (run)    cnt <= last ? '0 : cnt + CW'(1);
  end

  always_comb begin
    main_rdy  = run && (cnt < read_len);
    main_addr = (cnt < CW'(kq)) ? cnt[AW-1:0] : AW'(cnt - CW'(win));
    tail_rdy  = run && (cnt < CW'(TAIL_LEN));
    tail_addr = (idx_odd ? 3'd3 : 3'd0) + cnt[2:0];
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < period));
  p_tail_first_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(tail_rdy) |-> (tail_addr == 3'd0 || tail_addr == 3'd3));
endmodule

// File: rtl/hi_sequencer.sv
module hi_sequencer
  import hi_seq_pkg::*;
#(
  parameter int KW = 13,
  parameter int LW = 7,
  parameter int NW = 6,
  parameter int ZW = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [KW-1:0]   blk_len,
  input  logic [LW-1:0]   win_len,
  input  logic [NW-1:0]   last_idx,
  input  logic [1:0]      stop_mode,
  input  logic [ZW-1:0]   stop_thr,
  input  logic [ZW-1:0]   min_mag,
  output logic [NW-1:0]   half_idx,
  output logic            dec_done,
  output logic            main_rdy,
  output logic [KW-4:0]   main_addr,
  output logic            tail_rdy,
  output logic [2:0]      tail_addr
);
  localparam int AW = KW - 3;

  logic           busy, pend, last, hit, final_hi, accept;
  logic [AW-1:0]  kq_q;
  logic [LW-1:0]  win_q;
  logic [NW-1:0]  ni_q, na_q;
  logic [ZW-1:0]  thr_q;
  stop_mode_e     mode_q;

  always_comb begin
    final_hi = (na_q == ni_q) || pend;
    accept   = start && (!busy || (last && final_hi));
    dec_done = !busy;
    half_idx = na_q;
  end

  hi_stop_judge #(.ZW(ZW)) u_judge (
    .mode(mode_q), .idx_odd(na_q[0]), .thr(thr_q), .mag(min_mag), .hit(hit)
  );

  hi_phase_timer #(.AW(AW), .LW(LW)) u_timer (
    .clk(clk), .rst(rst), .run(busy), .clr(accept),
    .kq(kq_q), .win(win_q), .idx_odd(na_q[0]),
    .last(last), .main_rdy(main_rdy), .main_addr(main_addr),
    .tail_rdy(tail_rdy), .tail_addr(tail_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; pend <= 1'b0; na_q <= '0;
      kq_q <= '0; win_q <= '0; ni_q <= '0; thr_q <= '0;
      mode_q <= STOP_NEVER;
    end else if (accept) begin
      busy   <= 1'b1;
      pend   <= 1'b0;
      na_q   <= '0;
      kq_q   <= blk_len[KW-1:3];
      win_q  <= win_len;
      ni_q   <= last_idx;
      thr_q  <= stop_thr;
      mode_q <= stop_mode_e'(stop_mode);
    end else if (busy && last) begin
      if (final_hi) begin
        busy <= 1'b0;
        pend <= 1'b0;
      end else begin
        na_q <= na_q + NW'(1);
        pend <= hit;
      end
    end
  end

  p_idx_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> $stable(half_idx));
  p_idx_step_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && last && !final_hi && !start) |=> (half_idx == $past(half_idx) + NW'(1)));
  p_idx_bound_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (half_idx <= ni_q));
  p_quiet_idle_r4: assert property (@(posedge clk) disable iff (rst)
    dec_done |-> (!main_rdy && !tail_rdy));
  p_ignore_start_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !last && start) |=> (!dec_done && $stable(half_idx)));
  p_extra_ends_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && last && pend) |=> (dec_done || half_idx == '0));
endmodule

// File: tb/hi_sequencer_bench.sv
module hi_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  localparam int WATCHDOG = 150000;

  localparam int VK[NV]  = '{40, 40, 40, 40, 40, 40, 40, 40, 512, 40};
  localparam int VL[NV]  = '{5, 5, 5, 5, 5, 5, 5, 5, 32, 5};
  localparam int VN[NV]  = '{3, 9, 9, 9, 5, 5, 2, 0, 1, 63};
  localparam int VM[NV]  = '{0, 3, 1, 2, 3, 3, 3, 3, 0, 0};
  localparam int VT[NV]  = '{10, 20, 20, 20, 20, 20, 15, 5, 5, 5};
  localparam int VB[NV]  = '{100, 0, 0, 0, 20, 21, 0, 127, 127, 127};
  localparam int VS[NV]  = '{0, 4, 4, 4, 0, 0, 10, 0, 0, 0};

  logic clk = 0, rst = 1, start = 0;
  logic [12:0] blk_len = 13'd40;
  logic [6:0]  win_len = 7'd5, stop_thr = 7'd5, min_mag = '0;
  logic [5:0]  last_idx = '0;
  logic [1:0]  stop_mode = '0;
  logic [5:0]  half_idx;
  logic        dec_done, main_rdy, tail_rdy;
  logic [9:0]  main_addr;
  logic [2:0]  tail_addr;

  int checks = 0, fails = 0, cyc_total = 0;
  bit wd_hit = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hi_sequencer u_hi_sequencer (
    .clk(clk), .rst(rst), .start(start), .blk_len(blk_len), .win_len(win_len),
    .last_idx(last_idx), .stop_mode(stop_mode), .stop_thr(stop_thr),
    .min_mag(min_mag), .half_idx(half_idx), .dec_done(dec_done),
    .main_rdy(main_rdy), .main_addr(main_addr), .tail_rdy(tail_rdy),
    .tail_addr(tail_addr)
  );

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > WATCHDOG && !wd_hit) begin
      wd_hit = 1;
      fails++; checks++;
      $display("FAIL watchdog R2 actual=%0d expected<=%0d", cyc_total, WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit allow(int m, int n);
    case (m)
      1: return (n % 2) == 0;
      2: return (n % 2) == 1;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int mag_at(int b, int s, int n);
    int v = b + s * n;
    return (v > 127) ? 127 : v;
  endfunction

  // R7 R8 R9: expected number of half-iterations
  function automatic int exp_halves(int ni, int m, int th, int b, int s);
    for (int n = 0; n <= ni; n++) begin
      if (n == ni) return n + 1;
      if (allow(m, n) && mag_at(b, s, n) > th) return n + 2;
    end
    return ni + 1;
  endfunction

  task automatic pulse_start(int k, int l, int ni, int m, int th);
    @(negedge clk);
    blk_len = 13'(k); win_len = 7'(l); last_idx = 6'(ni);
    stop_mode = 2'(m); stop_thr = 7'(th); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // Runs one decode; optional mid-decode start with other settings at cycle poke.
  task automatic run_one(int k, int l, int ni, int m, int th, int b, int s, int poke);
    int p = k/8 + 2*l + 10, h = exp_halves(ni, m, th, b, s);
    int cyc = 0, maxna = 0, mains = 0, tails = 0, prof_bad = 0;
    pulse_start(k, l, ni, m, th);
    while (dec_done == 0 && cyc < 20000) begin
      int c = cyc % p;
      int ea = (c < k/8) ? c : c - l;
      int et = (half_idx[0] ? 3 : 0) + c;
      min_mag = 7'(mag_at(b, s, half_idx));
      if (half_idx > maxna) maxna = half_idx;
      if (main_rdy) mains++;
      if (tail_rdy) tails++;
      if (main_rdy != (c < k/8 + l)) prof_bad++;
      if (main_rdy && main_addr != 10'(ea)) prof_bad++;
      if (tail_rdy != (c < 3)) prof_bad++;
      if (tail_rdy && tail_addr != 3'(et)) prof_bad++;
      if (half_idx != 6'(cyc / p)) prof_bad++;
      if (cyc == poke) begin
        start = 1; last_idx = 6'd1; blk_len = 13'd512; win_len = 7'd60; stop_mode = 2'd3;
      end else start = 0;
      cyc++;
      @(negedge clk);
    end
    start = 0;
    chk("R2 busy length", cyc, h * p);
    chk("R3 final index", maxna, h - 1);
    chk("R4 main strobe count", mains, h * (k/8 + l));
    chk("R5 tail strobe count", tails, h * 3);
    chk("R4 R5 per-cycle profile", prof_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset done/idx/strobes", {dec_done, half_idx, main_rdy, tail_rdy}, {1'b1, 6'd0, 1'b0, 1'b0});
    rst = 0;
    @(negedge clk);
    chk("R1 idle after reset", dec_done, 1);

    // Vector table: R2 R3 R4 R5 R7 R8 R9
    for (int i = 0; i < NV; i++)
      run_one(VK[i], VL[i], VN[i], VM[i], VT[i], VB[i], VS[i], -1);

    // R6 R10: start with new settings mid-decode ignored
    run_one(40, 5, 3, 0, 10, 0, 0, 7);

    // R6: start in the final cycle restarts without done rising
    begin
      int p = 25, cyc = 0, seen_done = 0;
      pulse_start(40, 5, 1, 0, 10);
      while (cyc < 2*p - 1) begin cyc++; @(negedge clk); end
      start = 1;
      @(negedge clk);
      start = 0;
      chk("R6 restart keeps done low", dec_done, 0);
      chk("R6 restart index zero", half_idx, 0);
      cyc = 0;
      while (dec_done == 0 && cyc < 1000) begin cyc++; @(negedge clk); end
      chk("R6 second decode length", cyc, 2*p);
      if (seen_done != 0) chk("R6", seen_done, 0);
    end

    // R1 reset mid-decode
    pulse_start(40, 5, 5, 0, 10);
    repeat (10) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk("R1 reset mid-decode", {dec_done, half_idx, main_rdy, tail_rdy}, {1'b1, 6'd0, 1'b0, 1'b0});
    rst = 0;

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule